// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block turns single read or write requests from a processor core into timed external data memory cycles. A request carries a direction, an address and write data. It is accepted only while the block is idle. The block then drives the address with an address-valid qualifier, plus a read or write strobe, for a number of clock cycles set by a 3-bit stretch field.

Larger stretch values widen the cycle, so that slow or shared memory has time to respond. A stretch of 0 gives the shortest access. The field comes out of reset at 1. Read and write cycles follow different width rules:

- A write holds its address one cycle longer than a read.
- A write strobe is never shorter than one cycle.

At the end of every cycle the block raises a one-cycle done pulse. For reads, the captured data is presented together with that pulse.

Top module: `xmem_cycle_gen`

## Requirements
- R1: After reset the stretch field reads 1 on `stretch_o`. `busy`, `mem_addr_valid`, `mem_rd`, `mem_wr` and `done` are all low.
- R2: For a read accepted with stretch value s, `mem_addr_valid` is high for exactly s+1 consecutive cycles. These cycles start in the cycle after the accepting clock edge.
- R3: In a read cycle `mem_rd` is high in exactly the same cycles as `mem_addr_valid`. `mem_wr` stays low.
- R4: For a write accepted with stretch value s, `mem_addr_valid` is high for exactly s+2 consecutive cycles.
- R5: In a write cycle `mem_wr` is high for max(s,1) consecutive cycles. It ends on the last address-valid cycle. `mem_rd` stays low.
- R6: `rd_data` takes the value that `mem_rdata` has in the final `mem_rd` cycle. It holds that value until the next read ends.
- R7: `done` is high for exactly one cycle, in the cycle right after `mem_addr_valid` falls, for both reads and writes.
- R8: `req_valid` while `busy` is high is ignored. No further memory cycle starts from such a request, and `mem_addr` keeps the accepted address.
- R9: A write to the stretch field (`cfg_we`) updates `stretch_o` on the next clock edge. The new value applies only to requests accepted afterwards. A cycle already in flight keeps the width it started with.
- R10: `mem_addr` and `mem_wdata` are stable while `mem_addr_valid` is high. `mem_rd` and `mem_wr` are never high together, and the written data equals the request's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the stretch field |
| cfg_stretch | input | 3 | New stretch value |
| stretch_o | output | 3 | Current stretch value |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Request write data |
| busy | output | 1 | A cycle is in progress or finishing |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_addr_valid | output | 1 | Address phase qualifier |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_rdata | input | 8 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read data |

## Verification
Two situations are the hardest to reach from the ports. One is a stretch-field write that lands while a memory cycle is already running. The other is a request that stays asserted for the whole of a busy cycle. To reach the first, the stimulus writes a new stretch value during the first address cycle. It then confirms that the running cycle keeps its old width and that the next one uses the new width. To reach the second, `req_valid` is held high with a different address until `done`, and the bench then confirms that no second cycle starts. The bench memory returns data that changes on every strobe cycle, so a capture one cycle early or late shows up as a wrong value.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_ADDR = 2'd1,
    XS_DONE = 2'd2
  } xmc_state_e;

  // Address-phase length in cycles for a given stretch value and direction.
  function automatic int unsigned addr_cycles(input int unsigned s, input logic is_wr);
    return is_wr ? (s + 2) : (s + 1);
  endfunction

  // Write-strobe length: never below one cycle.
  function automatic int unsigned wstrobe_cycles(input int unsigned s);
    return (s < 2) ? 1 : s;
  endfunction

endpackage

// File: rtl/xmc_stretch_reg.sv
module xmc_stretch_reg #(
  parameter int SW      = 3,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wval,
  output logic [SW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= SW'(RST_VAL);
    else if (we) q <= wval;
  end

  assert_reset_val_R1: assert property (@(posedge clk)
    $past(rst) |-> (q == SW'(RST_VAL)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(we) && !$past(rst)) |-> $stable(q));

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst)) |-> (q == $past(wval)));

endmodule

// File: rtl/xmc_sequencer.sv
module xmc_sequencer
  import xmc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] stretch,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_av,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done,
  output logic          cap_en
);

  // Counter must hold addr_cycles(max stretch, write) - 1 = 2**SW.
  localparam int CW = SW + 1;

  xmc_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] wlen;
  logic          is_wr;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = cnt - CW'(1);
  assign busy    = (state != XS_IDLE);
  assign cap_en  = (state == XS_ADDR) && (cnt == '0) && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      cnt       <= '0;
      wlen      <= '0;
      is_wr     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_av    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        XS_IDLE: begin
          if (req_valid) begin
            state     <= XS_ADDR;
            is_wr     <= req_write;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
            cnt       <= CW'(addr_cycles(int'(stretch), req_write) - 1);
            wlen      <= CW'(wstrobe_cycles(int'(stretch)));
            mem_av    <= 1'b1;
            mem_rd    <= !req_write;
            // The first write cycle is always ahead of the strobe window.
            mem_wr    <= 1'b0;
          end
        end
        XS_ADDR: begin
          if (cnt == '0) begin
            state  <= XS_DONE;
            mem_av <= 1'b0;
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt    <= cnt_dec;
            mem_wr <= is_wr && (cnt_dec < wlen);
          end
        end
        XS_DONE: state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rd_in_av_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> mem_av);

  assert_wr_in_av_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_av);

  assert_wr_last_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |-> $fell(mem_av));

  assert_done_after_av_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_av) |-> done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_av && $past(mem_av)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mem_addr));

endmodule

// File: rtl/xmc_rd_capture.sv
module xmc_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (cap_en) rd_data <= mem_rdata;
  end

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_en) |-> $stable(rd_data));

endmodule

// File: rtl/xmem_cycle_gen.sv
module xmem_cycle_gen #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int STRETCH_RST = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_stretch,
  output logic [SW-1:0] stretch_o,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_addr_valid,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] rd_data
);

  logic cap_en;

  xmc_stretch_reg #(.SW(SW), .RST_VAL(STRETCH_RST)) u_stretch (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wval (cfg_stretch),
    .q    (stretch_o)
  );

  xmc_sequencer #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .stretch   (stretch_o),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_av    (mem_addr_valid),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .cap_en    (cap_en)
  );

  xmc_rd_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_addr_valid && !mem_rd && !mem_wr));

endmodule

// File: tb/xmem_cycle_gen_tb.sv
`timescale 1ns/1ps
module xmem_cycle_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_stretch = 3'd0;
  logic [2:0]  stretch_o;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        busy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_addr_valid, mem_rd, mem_wr;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [7:0]  rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xmem_cycle_gen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
    .stretch_o(stretch_o), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_addr_valid(mem_addr_valid), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .done(done), .rd_data(rd_data)
  );

  // Bench memory model: read data shifts with every strobe cycle.
  logic [7:0]  rdc = 8'h0;
  logic [15:0] wseen_addr = 16'h0;
  logic [7:0]  wseen_data = 8'h0;

  function automatic logic [7:0] rdgen(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8];
  endfunction

  assign mem_rdata = mem_rd ? (rdgen(mem_addr) + rdc) : 8'h00;

  always @(posedge clk) begin
    if (mem_rd) rdc <= rdc + 8'd1;
    else        rdc <= 8'h0;
    if (mem_wr) begin
      wseen_addr <= mem_addr;
      wseen_data <= mem_wdata;
    end
  end

  function automatic int exp_av(input int s, input bit wr);
    return wr ? s + 2 : s + 1;
  endfunction

  function automatic int exp_wr(input int s);
    return (s < 2) ? 1 : s;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic set_stretch(input logic [2:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_stretch = v;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(stretch_o == v, "R9 stretch update", int'(stretch_o), int'(v));
  endtask

  // One memory cycle. s is the stretch value in force at acceptance.
  task automatic run_cycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input int s, input bit poke, input logic [2:0] pval,
                           input bit spam);
    int idx = 1;
    int av_len = 0, rd_len = 0, wr_len = 0, wr_last = 0, done_idx = 0;
    int addr_bad = 0, both = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    if (spam) begin
      req_addr  = a ^ 16'hFFFF;
      req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    while (idx <= 40) begin
      if (mem_addr_valid) begin
        av_len++;
        if (mem_addr != a) addr_bad++;
      end
      if (mem_rd) rd_len++;
      if (mem_wr) begin wr_len++; wr_last = idx; end
      if (mem_rd && mem_wr) both++;
      if (done) begin done_idx = idx; break; end
      if (poke && idx == 1) begin cfg_we = 1'b1; cfg_stretch = pval; end
      if (poke && idx == 2) cfg_we = 1'b0;
      @(negedge clk);
      idx++;
    end
    req_valid = 1'b0;
    cfg_we = 1'b0;
    if (wr) begin
      chk(av_len == exp_av(s, 1), "R4 write address length", av_len, exp_av(s, 1));
      chk(wr_len == exp_wr(s), "R5 write strobe length", wr_len, exp_wr(s));
      chk(wr_last == av_len, "R5 write strobe ends with address", wr_last, av_len);
      chk(rd_len == 0, "R5 no read strobe on write", rd_len, 0);
      chk(wseen_data == d, "R10 written data", int'(wseen_data), int'(d));
      chk(wseen_addr == a, "R10 written address", int'(wseen_addr), int'(a));
    end else begin
      chk(av_len == exp_av(s, 0), "R2 read address length", av_len, exp_av(s, 0));
      chk(rd_len == av_len, "R3 read strobe length", rd_len, av_len);
      chk(wr_len == 0, "R3 no write strobe on read", wr_len, 0);
      chk(rd_data == rdgen(a) + 8'(s), "R6 captured read data",
          int'(rd_data), int'(rdgen(a) + 8'(s)));
    end
    chk(addr_bad == 0 && both == 0, "R10 address stable, strobes exclusive", addr_bad + both, 0);
    chk(done_idx == av_len + 1, "R7 done position", done_idx, av_len + 1);
    @(negedge clk);
    chk(!done, "R7 done single pulse", int'(done), 0);
    if (!wr) chk(rd_data == rdgen(a) + 8'(s), "R6 read data held",
                 int'(rd_data), int'(rdgen(a) + 8'(s)));
    if (spam) begin
      repeat (3) begin
        @(negedge clk);
        chk(!mem_addr_valid && !busy, "R8 request during busy ignored",
            int'(mem_addr_valid), 0);
      end
    end
    if (poke) chk(stretch_o == pval, "R9 stretch written mid-cycle",
                  int'(stretch_o), int'(pval));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cur_s;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(stretch_o == 3'd1, "R1 stretch reset value", int'(stretch_o), 1);
    chk(!busy && !mem_addr_valid && !mem_rd && !mem_wr && !done,
        "R1 outputs idle after reset",
        int'({busy, mem_addr_valid, mem_rd, mem_wr, done}), 0);

    // Reset stretch value in use before any write to the field.
    run_cycle(0, 16'h1234, 8'h00, 1, 0, 3'd0, 0);
    run_cycle(1, 16'h2345, 8'h5A, 1, 0, 3'd0, 0);

    // Every stretch value, both directions.
    for (int s = 0; s < 8; s++) begin
      set_stretch(3'(s));
      run_cycle(0, 16'h0100 + 16'(s * 17), 8'h00, s, 0, 3'd0, 0);
      run_cycle(1, 16'h8000 + 16'(s * 33), 8'(8'hC0 + s), s, 0, 3'd0, 0);
    end

    // Stretch change during a running cycle: old width now, new width next.
    set_stretch(3'd2);
    run_cycle(0, 16'hBEEF, 8'h00, 2, 1, 3'd6, 0);
    run_cycle(0, 16'hCAFE, 8'h00, 6, 0, 3'd0, 0);
    run_cycle(1, 16'hF00D, 8'h77, 6, 1, 3'd0, 0);
    run_cycle(1, 16'h0F0F, 8'h99, 0, 0, 3'd0, 0);

    // Requests held high across busy cycles.
    run_cycle(0, 16'h4242, 8'h00, 0, 0, 3'd0, 1);
    set_stretch(3'd7);
    run_cycle(1, 16'h5151, 8'h3C, 7, 0, 3'd0, 1);

    // Constrained random mix.
    cur_s = 7;
    for (int i = 0; i < 60; i++) begin
      bit          wr;
      logic [15:0] a;
      logic [7:0]  d;
      bit          poke;
      logic [2:0]  pv;
      wr   = 1'($urandom % 2);
      a    = 16'($urandom);
      d    = 8'($urandom);
      poke = (($urandom % 4) == 0);
      pv   = 3'($urandom % 8);
      run_cycle(wr, a, d, cur_s, poke, pv, (($urandom % 5) == 0));
      if (poke) cur_s = int'(pv);
      if (($urandom % 6) == 0) begin
        cur_s = int'($urandom % 8);
        set_stretch(3'(cur_s));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule